// File: doc/BRIEF.md
# Isochronous Interval Pulse Generator

This block produces a periodic interrupt that is locked to a shared nanosecond time base. The time base itself lives outside the block. It presents its middle time word, whose unit is 16 ns. The block scales that word by 16 to get nanoseconds. It then compares the result against a programmed start time. When that time is reached, the block fires one timing tick and sets a pending flag. On its own, it then moves the start time forward by the programmed interval, so the sequence of ticks keeps running with no accumulated drift.

Software uses one synchronous write port with four word addresses:

| Address | Register |
|---------|----------|
| 0 | Next-start time (ns) |
| 1 | Interval length (ns) |
| 2 | Mask |
| 3 | Write-one-to-clear status |

The next-start register can be read back, and so can the pending flag and the masked interrupt. A two-state controller holds the block idle until a start time is written:

- **`ST_IDLE`**: nothing is compared.
- **`ST_ARMED`**: the block compares the time against the start time on every clock edge.

The controller has four transitions:

- **arm** (`ST_IDLE` to `ST_ARMED`): a write to address 0.
- **advance** (`ST_ARMED` to `ST_ARMED`): a hit with a nonzero interval.
- **finish** (`ST_ARMED` to `ST_IDLE`): a hit with a zero interval.
- **rearm** (`ST_ARMED` to `ST_ARMED`): a write to address 0 while armed.

Top module: `iso_pulse_gen`

## Requirements
- R1: Reset is asynchronous and active low. After reset, `pending_o`, `irq_o`, `tick_o` and `next_start_o` are all 0, the mask bit is 1, and the controller is in `ST_IDLE`. In `ST_IDLE` no tick occurs, whatever the time input is.
- R2: While armed, the block evaluates a hit at each rising edge, using `time_mid` and `next_start_o` as they stand before that edge. Let `cur = time_mid << 4`, truncated to 32 bits. A hit occurs when `cur - next_start_o`, taken modulo 2^32 and read as a signed number, is zero or positive. Each hit gives a `tick_o` pulse lasting exactly the one cycle after that edge.
- R3: A write of `wr_data` to address 0 loads `next_start_o` and arms the controller. When such a write lands on the same edge as a hit, the written value wins over the automatic advance, but the tick and the pending flag still occur.
- R4: On a hit with a nonzero interval, `next_start_o` becomes exactly its old value plus the interval (modulo 2^32), and the block stays armed. After N hits with no writes, the register equals the start value plus N times the interval.
- R5: A write to address 1 sets the interval. A hit taken while the interval is 0 returns the controller to `ST_IDLE`. No further ticks follow until address 0 is written again.
- R6: Wraparound is handled through the signed difference. A start time that has wrapped past 2^32 ahead of `cur` does not fire until `cur` itself wraps and reaches it.
- R7: `pending_o` becomes 1 on every hit. A write to address 3 with bit 0 set clears it. A write to address 3 with bit 0 clear has no effect. If a hit and a clear fall on the same edge, the flag ends up 1.
- R8: Bit 0 of address 2 is the mask. `irq_o` equals `pending_o` when the mask bit is 0, and `irq_o` is 0 when the mask bit is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register word address |
| wr_data | input | 32 | Register write data |
| time_mid | input | 32 | Middle time word from the time base, in units of 16 ns |
| next_start_o | output | 32 | Current next-start register (ns) |
| tick_o | output | 1 | One-cycle pulse per hit, not affected by the mask |
| pending_o | output | 1 | Sticky pending flag (status bit 0) |
| irq_o | output | 1 | Pending flag gated by the mask |

## Verification
The assertions take three things for granted about the inputs:

- No register write is presented while reset is held, since a write in the reset cycle would be dropped, and the write-wins check would then see a stale value.
- `time_mid` is a synchronous signal that changes only after clock edges.
- An interval change shows its effect only on the next hit.

The stimulus keeps within these limits in four ways:

- It drives writes and time loads only at falling edges.
- It holds `wr_en` low throughout every reset.
- It loads a new time value only while the block is idle after reset.
- It writes the interval before arming.

// File: rtl/iso_pulse_pkg.sv
package iso_pulse_pkg;

    localparam int REG_AW = 2;

    localparam logic [REG_AW-1:0] ADDR_NEXT = 2'd0;
    localparam logic [REG_AW-1:0] ADDR_ILEN = 2'd1;
    localparam logic [REG_AW-1:0] ADDR_MASK = 2'd2;
    localparam logic [REG_AW-1:0] ADDR_STAT = 2'd3;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_ARMED = 1'b1
    } arm_state_t;

endpackage

// File: rtl/iso_cfg_regs.sv
module iso_cfg_regs
    import iso_pulse_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    output logic [DW-1:0]     ilen_q,
    output logic              mask_q,
    output logic              ns_wr,
    output logic              clr_req
);

    // Next-start loads and status clears are decoded here;
    // the controller and the flag own the storage.
    always_comb begin
        ns_wr   = wr_en && (wr_addr == ADDR_NEXT);
        clr_req = wr_en && (wr_addr == ADDR_STAT) && wr_data[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ilen_q <= '0;
            mask_q <= 1'b1;
        end else if (wr_en) begin
            if (wr_addr == ADDR_ILEN) begin
                ilen_q <= wr_data;
            end
            if (wr_addr == ADDR_MASK) begin
                mask_q <= wr_data[0];
            end
        end
    end

endmodule

// File: rtl/iso_reach_cmp.sv
module iso_reach_cmp #(
    parameter int DW    = 32,
    parameter int SHIFT = 4
) (
    input  logic [DW-1:0] time_word,
    input  logic [DW-1:0] target,
    output logic          reached
);

    logic [DW-1:0] scaled;
    logic [DW-1:0] diff;

    generate
        if (SHIFT == 0) begin : g_noscale
            assign scaled = time_word;
        end else begin : g_scale
            assign scaled = {time_word[DW-SHIFT-1:0], {SHIFT{1'b0}}};
        end
    endgenerate

    // Modular distance; its sign bit tells whether target lies ahead.
    assign diff    = scaled - target;
    assign reached = ~diff[DW-1];

endmodule

// File: rtl/iso_arm_fsm.sv
module iso_arm_fsm
    import iso_pulse_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ns_wr,
    input  logic [DW-1:0] ns_wr_data,
    input  logic [DW-1:0] ilen,
    input  logic          reached,
    output logic [DW-1:0] next_start_q,
    output logic          hit,
    output logic          tick_q
);

    arm_state_t    st_q;
    arm_state_t    st_nx;
    logic [DW-1:0] ns_nx;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_nx;
        end
    end

    // Transitions and next values
    always_comb begin
        st_nx = st_q;
        ns_nx = next_start_q;
        hit   = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (ns_wr) begin
                    st_nx = ST_ARMED;          // arm
                    ns_nx = ns_wr_data;
                end
            end
            ST_ARMED: begin
                if (reached) begin
                    hit = 1'b1;
                    if (ilen == '0) begin
                        st_nx = ST_IDLE;       // finish
                    end else begin
                        ns_nx = next_start_q + ilen;  // advance
                    end
                end
                if (ns_wr) begin
                    st_nx = ST_ARMED;          // rearm, write wins
                    ns_nx = ns_wr_data;
                end
            end
            default: begin
                st_nx = ST_IDLE;
            end
        endcase
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            next_start_q <= '0;
            tick_q       <= 1'b0;
        end else begin
            next_start_q <= ns_nx;
            tick_q       <= hit;
        end
    end

endmodule

// File: rtl/iso_pend_flag.sv
module iso_pend_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic mask_i,
    output logic pend_q,
    output logic irq
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (set_i) begin
            pend_q <= 1'b1;
        end else if (clr_i) begin
            pend_q <= 1'b0;
        end
    end

    assign irq = pend_q & ~mask_i;

endmodule

// File: rtl/iso_pulse_gen.sv
module iso_pulse_gen
    import iso_pulse_pkg::*;
#(
    parameter int DW    = 32,
    parameter int SHIFT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [DW-1:0]     time_mid,
    output logic [DW-1:0]     next_start_o,
    output logic              tick_o,
    output logic              pending_o,
    output logic              irq_o
);

    logic [DW-1:0] ilen_w;
    logic          mask_w;
    logic          ns_wr_w;
    logic          clr_w;
    logic          reached_w;
    logic          hit_w;

    iso_cfg_regs #(.DW(DW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ilen_q  (ilen_w),
        .mask_q  (mask_w),
        .ns_wr   (ns_wr_w),
        .clr_req (clr_w)
    );

    iso_reach_cmp #(.DW(DW), .SHIFT(SHIFT)) u_cmp (
        .time_word (time_mid),
        .target    (next_start_o),
        .reached   (reached_w)
    );

    iso_arm_fsm #(.DW(DW)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .ns_wr        (ns_wr_w),
        .ns_wr_data   (wr_data),
        .ilen         (ilen_w),
        .reached      (reached_w),
        .next_start_q (next_start_o),
        .hit          (hit_w),
        .tick_q       (tick_o)
    );

    iso_pend_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (hit_w),
        .clr_i  (clr_w),
        .mask_i (mask_w),
        .pend_q (pending_o),
        .irq    (irq_o)
    );

endmodule

// File: rtl/iso_pulse_gen_chk.sv
module iso_pulse_gen_chk
    import iso_pulse_pkg::*;
#(
    parameter int DW = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [REG_AW-1:0] wr_addr,
    input logic [DW-1:0]     wr_data,
    input logic [DW-1:0]     ilen,
    input logic [DW-1:0]     next_start_o,
    input logic              tick_o,
    input logic              pending_o,
    input logic              irq_o
);

    a_r7_tick_sets_pending: assert property (
        @(posedge clk) disable iff (!rst_n)
        tick_o |-> pending_o
    );

    a_r8_irq_needs_pending: assert property (
        @(posedge clk) disable iff (!rst_n)
        irq_o |-> pending_o
    );

    a_r3_write_wins: assert property (
        @(posedge clk) disable iff (!rst_n)
        $past(wr_en && (wr_addr == ADDR_NEXT)) |-> (next_start_o == $past(wr_data))
    );

    a_r4_exact_advance: assert property (
        @(posedge clk) disable iff (!rst_n)
        (tick_o && !$past(wr_en && (wr_addr == ADDR_NEXT)) && ($past(ilen) != '0))
        |-> (next_start_o == $past(next_start_o) + $past(ilen))
    );

    a_r4_hold_between_hits: assert property (
        @(posedge clk) disable iff (!rst_n)
        (!tick_o && !$past(wr_en && (wr_addr == ADDR_NEXT))) |-> $stable(next_start_o)
    );

    a_r7_w1c_clears: assert property (
        @(posedge clk) disable iff (!rst_n)
        ($past(wr_en && (wr_addr == ADDR_STAT) && wr_data[0]) && !tick_o) |-> !pending_o
    );

endmodule

bind iso_pulse_gen iso_pulse_gen_chk #(.DW(DW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .ilen         (ilen_w),
    .next_start_o (next_start_o),
    .tick_o       (tick_o),
    .pending_o    (pending_o),
    .irq_o        (irq_o)
);

// File: tb/iso_pulse_gen_test.sv
module iso_pulse_gen_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [31:0] wr_data = '0;
    logic [31:0] tb_time = '0;
    logic        tload = 1'b0;
    logic [31:0] tval = '0;
    logic [31:0] next_start_o;
    logic        tick_o;
    logic        pending_o;
    logic        irq_o;

    int n_chk = 0;
    int n_bad = 0;
    int n_ticks = 0;
    bit finished = 0;

    int unsigned exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (tload) tb_time <= tval;
        else       tb_time <= tb_time + 32'd1;
    end

    iso_pulse_gen uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .time_mid     (tb_time),
        .next_start_o (next_start_o),
        .tick_o       (tick_o),
        .pending_o    (pending_o),
        .irq_o        (irq_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: pops expected tick times as the design produces ticks
    always @(negedge clk) begin
        if (rst_n && tick_o) begin
            n_ticks++;
            n_chk++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R2 unexpected tick actual=%0h expected=none", tb_time - 32'd1);
            end else begin
                automatic int unsigned e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                if (tb_time - 32'd1 != e) begin
                    n_bad++;
                    $display("FAIL %s tick time actual=%0h expected=%0h", t, tb_time - 32'd1, e);
                end
            end
        end
    end

    // Expected-tick model from R2/R4/R5: pushes hit times for t in [tfrom, tto]
    function automatic logic [31:0] push_model(input logic [31:0] ns, input logic [31:0] ilen,
                                               input int unsigned tfrom, input int unsigned tto,
                                               input string tag);
        logic [31:0] n = ns;
        bit armed = 1'b1;
        for (int unsigned t = tfrom; t <= tto; t++) begin
            logic [31:0] cur;
            logic [31:0] d;
            cur = 32'(t) << 4;
            d = cur - n;
            if (armed && !d[31]) begin
                exp_q.push_back(t);
                tag_q.push_back(tag);
                if (ilen == 32'd0) armed = 1'b0;
                else n = n + ilen;
            end
        end
        return n;
    endfunction

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic load_time(input logic [31:0] v);
        tload = 1'b1; tval = v;
        @(negedge clk);
        tload = 1'b0;
    endtask

    task automatic check_drained(input string tag);
        #1;
        chk(tag, 32'(exp_q.size()), 32'd0);
        exp_q.delete();
        tag_q.delete();
    endtask

    // Arms with a start (d cycles after first evaluation, plus off ns) and checks W evaluations
    task automatic run_phase(input string tag, input logic [31:0] v, input int d,
                             input logic [31:0] off, input logic [31:0] ilen, input int w);
        logic [31:0] tw;
        logic [31:0] ns0;
        logic [31:0] nsf;
        do_reset();
        load_time(v);
        wr(2'd1, ilen);
        tw = tb_time;
        ns0 = (32'(int'(tw) + 1 + d) << 4) + off;
        nsf = push_model(ns0, ilen, tw + 1, tw + 32'(w), tag);
        wr(2'd0, ns0);
        repeat (w) @(negedge clk);
        check_drained(tag);
        chk(tag, next_start_o, nsf);
    endtask

    initial begin
        @(negedge clk);
        // R1: values while in reset and after release
        chk("R1", {31'd0, pending_o}, 32'd0);
        chk("R1", {31'd0, irq_o}, 32'd0);
        chk("R1", {31'd0, tick_o}, 32'd0);
        chk("R1", next_start_o, 32'd0);
        do_reset();
        load_time(32'd5000);
        repeat (20) @(negedge clk);
        chk("R1", 32'(n_ticks), 32'd0);
        wr(2'd0, 32'd0);   // addr0 write arms; start 0 is behind, cur==... hit next edge
        exp_q.delete(); tag_q.delete();

        // R2/R4: periodic ticks, interval 160 ns
        run_phase("R4", 32'd100, 3, 32'd5, 32'd160, 60);
        chk("R7", {31'd0, pending_o}, 32'd1);
        chk("R8", {31'd0, irq_o}, 32'd0);

        // R5: zero interval gives a single tick
        run_phase("R5", 32'd300, 4, 32'd0, 32'd0, 50);

        // R4: interval not a multiple of 16, exact accumulation
        run_phase("R4", 32'd2000, 2, 32'd3, 32'd37, 80);

        // R2: interval shorter than a time step, hits every cycle
        run_phase("R2", 32'd700, 1, 32'd0, 32'd8, 30);

        // R6: start time past the 32-bit wrap
        run_phase("R6", 32'h0FFF_FFF0, 30, 32'd0, 32'd64, 80);

        // R2: start already in the past, catch-up then steady
        run_phase("R2", 32'd1000, -50, 32'd0, 32'd320, 60);

        // R3: write on the same edge as a hit
        begin
            logic [31:0] tw;
            logic [31:0] ns0;
            logic [31:0] nsn;
            logic [31:0] nsf;
            do_reset();
            load_time(32'd4000);
            wr(2'd1, 32'd16);
            tw = tb_time;
            ns0 = 32'(tw + 32'd4) << 4;
            void'(push_model(ns0, 32'd16, tw + 1, tw + 4, "R3"));
            wr(2'd0, ns0);
            repeat (3) @(negedge clk);
            nsn = 32'(tw + 32'd14) << 4;
            nsf = push_model(nsn, 32'd16, tw + 5, tw + 30, "R3");
            wr(2'd0, nsn);
            chk("R3", next_start_o, nsn);
            chk("R3", {31'd0, pending_o}, 32'd1);
            repeat (26) @(negedge clk);
            check_drained("R3");
            chk("R3", next_start_o, nsf);
        end

        // R7/R8: mask and write-one-to-clear
        run_phase("R7", 32'd50, 2, 32'd0, 32'd0, 10);
        chk("R7", {31'd0, pending_o}, 32'd1);
        chk("R8", {31'd0, irq_o}, 32'd0);
        wr(2'd2, 32'd0);
        chk("R8", {31'd0, irq_o}, 32'd1);
        wr(2'd3, 32'hFFFF_FFFE);
        chk("R7", {31'd0, pending_o}, 32'd1);
        wr(2'd3, 32'd1);
        chk("R7", {31'd0, pending_o}, 32'd0);
        chk("R8", {31'd0, irq_o}, 32'd0);

        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        end
        $finish;
    end

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        end
        $finish;
    end

endmodule